// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block generates the column addresses of a single SDRAM read or write burst, one address per clock. A controller presents a starting column together with an already-decoded burst length code and burst type bit, and pulses a start strobe. The sequencer then walks the columns in the order the memory expects: sequential or interleaved, wrapping inside the aligned block whose size equals the burst length. A full-page mode instead steps through the whole row, wrapping from the top column to column 0, and runs until a terminate strobe arrives.

The control is a three-state machine. IDLE waits for a legal start. BLOCK runs a fixed-length burst of 1, 2, 4 or 8 beats. PAGE runs an unbounded full-page burst. The transitions are: IDLE→BLOCK and IDLE→PAGE on a legal start; BLOCK→BLOCK on a legal start (restart) or on a non-final beat; BLOCK→IDLE on the final beat or a terminate; PAGE→PAGE on a legal start or each ordinary beat; PAGE→IDLE on a terminate; PAGE→BLOCK and BLOCK→PAGE on a legal start of the other kind. An illegal length/type pair never leaves its current state and raises an error pulse.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `cfg_err_o` are 0.
- R2: A legal start sampled at a clock edge makes `valid_o` 1 and `col_o` equal to `start_col_i` from that edge on. A legal start during a burst abandons it and restarts from the new column.
- R3: `len_code_i` values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `valid_o` stays high for exactly that many cycles, `last_o` is high only on the final beat, and `valid_o` is 0 on the following cycle unless a new start arrives.
- R4: In a fixed burst of length L = 2^n, column bits n and above stay equal to those of the start column on every beat.
- R5: With `interleave_i` = 0 (sequential), beat k has low n bits equal to (start + k) mod L.
- R6: With `interleave_i` = 1 (interleaved), beat k has low n bits equal to the start's low n bits XOR k.
- R7: `len_code_i` = 7 with `interleave_i` = 0 selects full page. The column increases by 1 each cycle, wraps from 2^COL_W-1 to 0, `last_o` stays 0, and the burst does not end by itself.
- R8: Codes 4, 5 and 6, and code 7 with `interleave_i` = 1, are reserved. A start with one of them starts no burst and leaves a running burst unchanged. `cfg_err_o` is 1 for the one cycle after that start.
- R9: A terminate sampled while `valid_o` is 1 makes the current beat the last one, and `valid_o` is 0 on the next cycle. A terminate while idle has no effect.
- R10: When a legal start and a terminate are sampled at the same edge, the start wins.
- R11: A length-1 burst shows the start column for one cycle with `last_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a burst from `start_col_i` |
| term_i | input | 1 | Cut the running burst after the current beat |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Length: 0→1, 1→2, 2→4, 3→8, 7→full page, others reserved |
| interleave_i | input | 1 | Burst type: 0 sequential, 1 interleaved |
| valid_o | output | 1 | `col_o` carries a burst beat |
| col_o | output | COL_W | Column address of the current beat |
| last_o | output | 1 | Final beat of a fixed-length burst |
| cfg_err_o | output | 1 | Pulse after a start with a reserved length/type pair |

## Verification
A corrupted beat counter or latched start column shows up on `col_o` in the very beat it affects: the wrong low bits break the sequential or interleaved order, and a carry leaking out of the block changes the upper bits. A stuck or wrong state shows up as `valid_o` running one cycle too long or too short, or `last_o` on the wrong beat, visible within at most eight cycles of the start. In full-page mode, a counter fault appears as a missing +1 step or a bad wrap at the top column on the next cycle. A decode fault shows one cycle after the start, as an error pulse together with a burst, or as a missing error.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // burst length codes as presented on len_code_i
    localparam logic [2:0] CODE_LEN1 = 3'd0;
    localparam logic [2:0] CODE_LEN2 = 3'd1;
    localparam logic [2:0] CODE_LEN4 = 3'd2;
    localparam logic [2:0] CODE_LEN8 = 3'd3;
    localparam logic [2:0] CODE_PAGE = 3'd7;

    // widest fixed burst is 2**BLK_LOG_MAX beats
    localparam int BLK_LOG_MAX = 3;
    localparam int LOG_W       = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLOCK = 2'd1,
        ST_PAGE  = 2'd2
    } bcs_state_e;

    typedef struct packed {
        logic             legal;
        logic             page;
        logic [LOG_W-1:0] len_log;
    } bcs_cfg_t;

endpackage

// File: rtl/bcs_cfg_dec.sv
module bcs_cfg_dec
    import bcs_pkg::*;
(
    input  logic [2:0] len_code,
    input  logic       interleave,
    output bcs_cfg_t   cfg
);

    always_comb begin
        cfg = '0;
        unique case (len_code)
            CODE_LEN1: begin cfg.legal = 1'b1; cfg.len_log = 2'd0; end
            CODE_LEN2: begin cfg.legal = 1'b1; cfg.len_log = 2'd1; end
            CODE_LEN4: begin cfg.legal = 1'b1; cfg.len_log = 2'd2; end
            CODE_LEN8: begin cfg.legal = 1'b1; cfg.len_log = 2'd3; end
            CODE_PAGE: begin
                // full page only exists in sequential order
                cfg.legal = ~interleave;
                cfg.page  = 1'b1;
            end
            default:   cfg = '0;
        endcase
    end

endmodule

// File: rtl/bcs_order.sv
module bcs_order
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int OFS_W = BLK_LOG_MAX
) (
    input  logic [COL_W-1:0] base,
    input  logic [OFS_W-1:0] beat,
    input  logic [LOG_W-1:0] len_log,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [OFS_W-1:0] seq_low;

    // carries past the block edge are dropped by the per-bit select below
    assign seq_low = base[OFS_W-1:0] + beat;

    for (genvar i = 0; i < OFS_W; i++) begin : g_low
        logic in_block;
        assign in_block = (LOG_W'(i) < len_log);
        assign col[i]   = !in_block  ? base[i] :
                          interleave ? (base[i] ^ beat[i]) : seq_low[i];
    end

    if (COL_W > OFS_W) begin : g_high
        assign col[COL_W-1:OFS_W] = base[COL_W-1:OFS_W];
    end

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int COL_W = 10,
    parameter int OFS_W = BLK_LOG_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             term,
    input  logic [COL_W-1:0] start_col,
    input  logic             interleave,
    input  bcs_cfg_t         cfg,
    output bcs_state_e       state,
    output logic [OFS_W-1:0] beat_q,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] page_q,
    output logic [LOG_W-1:0] len_log_q,
    output logic             inter_q,
    output logic             err_q,
    output logic             final_beat
);

    bcs_state_e state_nx;
    logic       go;

    assign go         = start & cfg.legal;
    assign final_beat = (state == ST_BLOCK) &&
                        (beat_q == OFS_W'((1 << len_log_q) - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (go) begin
            state_nx = cfg.page ? ST_PAGE : ST_BLOCK;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_BLOCK: if (term || final_beat) state_nx = ST_IDLE;
                ST_PAGE:  if (term)               state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q    <= '0;
            base_q    <= '0;
            page_q    <= '0;
            len_log_q <= '0;
            inter_q   <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q <= start & ~cfg.legal;
            if (go) begin
                beat_q    <= '0;
                base_q    <= start_col;
                page_q    <= start_col;
                len_log_q <= cfg.len_log;
                inter_q   <= interleave;
            end else if (state == ST_BLOCK && !final_beat) begin
                beat_q <= beat_q + OFS_W'(1);
            end else if (state == ST_PAGE) begin
                page_q <= page_q + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             interleave_i,
    output logic             valid_o,
    output logic [COL_W-1:0] col_o,
    output logic             last_o,
    output logic             cfg_err_o
);

    localparam int OFS_W = BLK_LOG_MAX;

    bcs_cfg_t         dec_cfg;
    bcs_state_e       state;
    logic [OFS_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] page_q;
    logic [LOG_W-1:0] len_log_q;
    logic             inter_q;
    logic             err_q;
    logic             final_beat;
    logic [COL_W-1:0] ord_col;
    logic             cfg_legal;
    logic             in_page;

    bcs_cfg_dec u_dec (
        .len_code   (len_code_i),
        .interleave (interleave_i),
        .cfg        (dec_cfg)
    );

    bcs_fsm #(.COL_W(COL_W), .OFS_W(OFS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_i),
        .term       (term_i),
        .start_col  (start_col_i),
        .interleave (interleave_i),
        .cfg        (dec_cfg),
        .state      (state),
        .beat_q     (beat_q),
        .base_q     (base_q),
        .page_q     (page_q),
        .len_log_q  (len_log_q),
        .inter_q    (inter_q),
        .err_q      (err_q),
        .final_beat (final_beat)
    );

    bcs_order #(.COL_W(COL_W), .OFS_W(OFS_W)) u_ord (
        .base       (base_q),
        .beat       (beat_q),
        .len_log    (len_log_q),
        .interleave (inter_q),
        .col        (ord_col)
    );

    assign cfg_legal = dec_cfg.legal;
    assign in_page   = (state == ST_PAGE);

    always_comb begin
        valid_o   = 1'b0;
        col_o     = '0;
        last_o    = 1'b0;
        cfg_err_o = err_q;
        unique case (state)
            ST_IDLE:  ;
            ST_BLOCK: begin
                valid_o = 1'b1;
                col_o   = ord_col;
                last_o  = final_beat;
            end
            ST_PAGE:  begin
                valid_o = 1'b1;
                col_o   = page_q;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
    parameter int COL_W = 10,
    parameter int BLK_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             term_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             valid_o,
    input logic [COL_W-1:0] col_o,
    input logic             last_o,
    input logic             cfg_err_o,
    input logic             cfg_legal,
    input logic             in_page
);

    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cfg_legal) |=> (valid_o && col_o == $past(start_col_i)));

    a_r3_last_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    a_r3_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    a_r4_block_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !in_page && !last_o && !term_i && !start_i)
        |=> (valid_o && $stable(col_o[COL_W-1:BLK_W])));

    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && in_page && !term_i && !start_i)
        |=> (valid_o && !last_o && col_o == $past(col_o) + COL_W'(1)));

    a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && start_i && !cfg_legal) |=> (!valid_o && cfg_err_o));

    a_r9_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && term_i && !start_i) |=> !valid_o);

endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W), .BLK_W(bcs_pkg::BLK_LOG_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .term_i      (term_i),
    .start_col_i (start_col_i),
    .valid_o     (valid_o),
    .col_o       (col_o),
    .last_o      (last_o),
    .cfg_err_o   (cfg_err_o),
    .cfg_legal   (cfg_legal),
    .in_page     (in_page)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

    localparam int COL_W = 10;
    localparam int NCOL  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             interleave_i = 1'b0;
    logic             valid_o;
    logic [COL_W-1:0] col_o;
    logic             last_o;
    logic             cfg_err_o;

    always #4 clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .term_i       (term_i),
        .start_col_i  (start_col_i),
        .len_code_i   (len_code_i),
        .interleave_i (interleave_i),
        .valid_o      (valid_o),
        .col_o        (col_o),
        .last_o       (last_o),
        .cfg_err_o    (cfg_err_o)
    );

    typedef struct {
        logic             v;
        logic [COL_W-1:0] c;
        logic             l;
        logic             e;
        string            tag;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference model state
    int m_mode = 0;   // 0 idle, 1 fixed, 2 page
    int m_base = 0, m_k = 0, m_len = 1, m_it = 0, m_pc = 0;

    task automatic step(input bit st, input int code, input bit it,
                        input int col, input bit tm, input string tag);
        exp_t x;
        bit   legal, err;
        @(negedge clk);
        start_i      = st;
        term_i       = tm;
        len_code_i   = 3'(code);
        interleave_i = it;
        start_col_i  = COL_W'(col);
        legal = (code <= 3) || (code == 7 && !it);
        err   = st && !legal;
        if (st && legal) begin
            if (code == 7) begin m_mode = 2; m_pc = col; end
            else begin
                m_mode = 1; m_len = 1 << code; m_base = col; m_k = 0; m_it = it;
            end
        end else if (m_mode != 0 && tm) m_mode = 0;
        else if (m_mode == 1) begin
            if (m_k == m_len - 1) m_mode = 0; else m_k++;
        end else if (m_mode == 2) m_pc = (m_pc + 1) % NCOL;
        x.v = (m_mode != 0);
        if (m_mode == 2) x.c = COL_W'(m_pc);
        else if (m_it != 0) x.c = COL_W'(m_base ^ m_k);
        else x.c = COL_W'((m_base / m_len) * m_len + ((m_base % m_len) + m_k) % m_len);
        x.l   = (m_mode == 1) && (m_k == m_len - 1);
        x.e   = err;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare outputs 3 ns after each rising edge
    always begin
        exp_t x;
        @(posedge clk);
        #3;
        if (q.size() > 0) begin
            x = q.pop_front();
            n_chk++;
            if (valid_o !== x.v || cfg_err_o !== x.e ||
                (x.v && (col_o !== x.c || last_o !== x.l))) begin
                n_fail++;
                $display("FAIL %s: got v=%0b col=%0d last=%0b err=%0b, expected v=%0b col=%0d last=%0b err=%0b",
                         x.tag, valid_o, col_o, last_o, cfg_err_o, x.v, x.c, x.l, x.e);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 reset idle");

        // every type, length and start offset against the ordering model
        for (int it = 0; it < 2; it++)
            for (int code = 0; code < 4; code++)
                for (int off = 0; off < 8; off++) begin
                    int hi = ((it * 32 + code * 8 + off) * 37) % 128;
                    string tg = (code == 0) ? "R11 R3" :
                                (it != 0)   ? "R6 R3/R4" : "R5 R3/R4";
                    step(1, code, it[0], hi * 8 + off, 0, tg);
                    idle(1 << code, tg);
                end

        // back-to-back bursts: start on the final beat
        step(1, 2, 0, 100, 0, "R2 back-to-back");
        idle(3, "R2 back-to-back");
        step(1, 1, 1, 203, 0, "R2 back-to-back");
        idle(2, "R2 back-to-back");

        // a new start in the middle of a burst aborts it
        step(1, 3, 0, 45, 0, "R2 abort");
        idle(2, "R2 abort");
        step(1, 3, 1, 518, 0, "R2 abort restart");
        idle(8, "R2 abort restart");

        // terminate in the middle of a fixed burst; terminate while idle
        step(1, 3, 0, 300, 0, "R9 term fixed");
        idle(2, "R9 term fixed");
        step(0, 0, 0, 0, 1, "R9 term fixed");
        idle(2, "R9 after term");
        step(0, 0, 0, 0, 1, "R9 term idle ignored");
        idle(1, "R9 term idle ignored");

        // start and terminate in the same cycle
        step(1, 2, 1, 77, 0, "R10 setup");
        step(1, 3, 0, 66, 1, "R10 start beats term");
        idle(8, "R10 start beats term");

        // full page across the top of the row, then terminated
        step(1, 7, 0, NCOL - 4, 0, "R7 page wrap");
        idle(10, "R7 page wrap");
        step(0, 0, 0, 0, 1, "R9 page term");
        idle(2, "R9 page term");

        // full page over more than a whole row
        step(1, 7, 0, 5, 0, "R7 page long");
        idle(NCOL + 6, "R7 page long");
        step(0, 0, 0, 0, 1, "R7 page long term");
        idle(1, "R7 page long term");

        // reserved codes while idle
        for (int code = 4; code < 7; code++) begin
            step(1, code, 0, 12, 0, "R8 reserved code");
            idle(1, "R8 reserved code");
        end
        step(1, 7, 1, 12, 0, "R8 page interleaved");
        idle(1, "R8 page interleaved");

        // reserved start during a burst leaves it running
        step(1, 3, 1, 131, 0, "R8 burst kept");
        step(0, 0, 0, 0, 0, "R8 burst kept");
        step(1, 5, 0, 900, 0, "R8 burst kept");
        idle(7, "R8 burst kept");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule